// File: doc/BRIEF.md
# Serial Receive Channel with Character Queue

This block is the receive half of one asynchronous serial channel. It watches a single line that idles high, times it with a clock enable that pulses sixteen times per bit, and rebuilds each character from a start bit, five to eight data bits sent least significant bit first, an optional parity bit and a stop bit. Every finished character goes into a sixteen-deep queue. Each queue entry holds the data byte together with that character's parity, framing and break flags.

The host sees the oldest character and its flags at the head of the queue. A one-cycle read strobe removes that character. Two interrupt sources serve the host. A level interrupt is raised while the queue holds at least a programmed number of characters. A timeout interrupt is raised when characters wait in the queue and the line has delivered nothing new for the length of a character plus twelve bit times. A sticky error summary and an overrun flag complete the status. Line format, queue clear and trigger choice arrive as already-decoded control fields.

Top module: `serial_rx_queue`

## Requirements
- R1: The character length is 5, 6, 7 or 8 data bits for `word_len` codes 0, 1, 2 and 3. The first data bit after the start bit lands in `rd_data[0]`. Bits above the character length read as 0.
- R2: With `par_en`=0 there is no parity bit. With `par_en`=1 and `par_stick`=0, the expected parity bit gives an even count of ones when `par_even`=1 and an odd count when `par_even`=0. With `par_stick`=1, the expected parity bit is 1 when `par_even`=0 and 0 when `par_even`=1. `rd_par_err` is 1 when the received parity bit differs from the expected one.
- R3: The queue holds 16 characters in arrival order. Each entry carries its own data and error flags to the head. A pulse on `rd_pop` removes the head entry, and `data_ready` is 1 whenever the queue is not empty.
- R4: `rd_frm_err` is 1 for a character whose stop bit was sampled low. `rd_brk` is 1 when all data bits, the parity bit (if enabled) and the stop bit were low. After such a character, no new start is seen until the line has returned high.
- R5: `fifo_err_any` is set when a character carrying any error flag enters the queue. It is cleared by a read of the head or by a queue clear.
- R6: A `fifo_clr` pulse empties the queue on the next edge. A character already in flight on the line is still received whole after the clear.
- R7: `level_irq` is 1 while the queue count is at least the trigger level: 1, 4, 8 or 14 characters for `trig_sel` codes 0, 1, 2 and 3.
- R8: `tmo_irq` rises (data bits + 12) × 16 baud ticks after the last change of the queue, provided the queue is not empty and the count has not changed in between. It is cleared by a read, a new character or a clear. `irq` is the OR of `level_irq` and `tmo_irq`.
- R9: A start bit is confirmed by a low sample at its middle, the eighth tick. A low pulse shorter than that is discarded and produces no character.
- R10: A character that completes while the queue is full is dropped and sets `overrun`. The queue contents stay unchanged. `overrun` is cleared by a read or a clear.
- R11: After reset the queue is empty, and all status and interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Enable pulsing 16 times per bit |
| rx_in | input | 1 | Serial line, idle high |
| word_len | input | 2 | Character length code |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select / stick value select |
| par_stick | input | 1 | Parity forced to a constant |
| trig_sel | input | 2 | Queue trigger level code |
| fifo_clr | input | 1 | Empty the queue (pulse) |
| rd_pop | input | 1 | Remove head character (pulse) |
| rd_data | output | 8 | Head character data |
| rd_par_err | output | 1 | Head character parity error |
| rd_frm_err | output | 1 | Head character framing error |
| rd_brk | output | 1 | Head character break |
| data_ready | output | 1 | Queue not empty |
| fifo_err_any | output | 1 | Sticky: an erroneous character entered the queue |
| overrun | output | 1 | Sticky: a character was dropped for lack of room |
| level_irq | output | 1 | Queue count at or above trigger level |
| tmo_irq | output | 1 | Character timeout |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong sampling phase or a wrong bit counter shows up at once on the next character: `rd_data` comes out shifted, or false parity and framing flags appear. An error flag that becomes detached from its data appears when the queue is drained, because the flags at the head no longer match the character that was sent with an error. A queue count that is off by one moves the edge of `level_irq`, blocks the overrun drop, or shifts the timeout interval. The bench measures that interval to within one cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] data;
    } rx_char_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
    } rx_state_t;

    function automatic logic [3:0] data_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic [4:0] trig_level(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

    // Parity bit the line should carry for the given data.
    function automatic logic want_parity(input logic [7:0] d, input logic even,
                                         input logic stick);
        if (stick) return ~even;
        return even ? (^d) : ~(^d);
    endfunction

endpackage

// File: rtl/rxq_framer.sv
module rxq_framer
    import rxq_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx_in,
    input  logic [1:0] word_len,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    output logic       push,
    output rx_char_t   push_char
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] MIDC = CW'(OVS / 2 - 2);

    logic          rx_s1, rx_s2;
    rx_state_t     state;
    logic [CW-1:0] cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    shreg;
    logic          par_bit;
    logic [2:0]    last_idx;

    assign last_idx = {1'b0, word_len} + 3'd4;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_s1 <= 1'b1;
            rx_s2 <= 1'b1;
        end else begin
            rx_s1 <= rx_in;
            rx_s2 <= rx_s1;
        end
    end

    always_ff @(posedge clk) begin
        push <= 1'b0;
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            par_bit   <= 1'b0;
            push_char <= '0;
        end else if (tick) begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (!rx_s2) state <= ST_START;
                end
                ST_START: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == MIDC) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        shreg   <= '0;
                        state   <= rx_s2 ? ST_IDLE : ST_DATA;
                    end
                end
                ST_DATA: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        cnt            <= '0;
                        shreg[bit_idx] <= rx_s2;
                        bit_idx        <= bit_idx + 1'b1;
                        if (bit_idx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        cnt     <= '0;
                        par_bit <= rx_s2;
                        state   <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        cnt            <= '0;
                        push           <= 1'b1;
                        push_char.data <= shreg;
                        push_char.par  <= par_en && (par_bit != want_parity(shreg, par_even, par_stick));
                        push_char.frm  <= !rx_s2;
                        push_char.brk  <= !rx_s2 && (shreg == 8'h00) && (!par_en || !par_bit);
                        state          <= rx_s2 ? ST_IDLE : ST_HOLD;
                    end
                end
                default: begin
                    if (rx_s2) state <= ST_IDLE;
                end
            endcase
        end
    end

    // R3: one push per character
    p_push_single_r3: assert property (@(posedge clk) disable iff (rst)
        push |=> !push);

    // R4: a low stop bit keeps the receiver away from a new start
    p_hold_after_low_r4: assert property (@(posedge clk) disable iff (rst)
        (push && push_char.frm) |-> (state == ST_HOLD));

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       wr,
    input  rx_char_t                   wdata,
    input  logic                       rd,
    output rx_char_t                   rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    rx_char_t        mem [DEPTH];
    logic [AW-1:0]   wptr, rptr;
    logic            do_wr, do_rd;

    assign full  = (count == CNTW'(DEPTH));
    assign do_wr = wr && !full;
    assign do_rd = rd && (count != '0);
    assign rdata = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= wptr + 1'b1;
            if (do_rd) rptr <= rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr && !rst && !clr) mem[wptr] <= wdata;
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        count <= CNTW'(DEPTH));

    p_full_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (full && wr && !rd && !clr) |=> (count == $past(count)));

    p_clear_empties_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OVS   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       rx_in,
    input  logic [1:0] word_len,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    input  logic [1:0] trig_sel,
    input  logic       fifo_clr,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    output logic       rd_par_err,
    output logic       rd_frm_err,
    output logic       rd_brk,
    output logic       data_ready,
    output logic       fifo_err_any,
    output logic       overrun,
    output logic       level_irq,
    output logic       tmo_irq,
    output logic       irq
);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int TW   = $clog2(20 * OVS + 1);

    logic            push, full, accept, ch_err;
    rx_char_t        pch, head;
    logic [CNTW-1:0] count;
    logic [TW-1:0]   tcnt, tmo_limit;

    rxq_framer #(.OVS(OVS)) u_framer (
        .clk, .rst, .tick(baud_tick), .rx_in, .word_len,
        .par_en, .par_even, .par_stick, .push, .push_char(pch)
    );

    rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk, .rst, .clr(fifo_clr), .wr(push), .wdata(pch),
        .rd(rd_pop), .rdata(head), .count, .full
    );

    assign rd_data    = head.data;
    assign rd_par_err = head.par;
    assign rd_frm_err = head.frm;
    assign rd_brk     = head.brk;
    assign data_ready = (count != '0);
    assign level_irq  = 32'(count) >= 32'(trig_level(trig_sel));
    assign irq        = level_irq || tmo_irq;
    assign accept     = push && !full && !fifo_clr;
    assign ch_err     = pch.par || pch.frm || pch.brk;
    assign tmo_limit  = TW'((32'(data_bits(word_len)) + 32'd12) * 32'(OVS));

    always_ff @(posedge clk) begin
        if (rst || fifo_clr) begin
            fifo_err_any <= 1'b0;
            overrun      <= 1'b0;
        end else begin
            if (accept && ch_err)       fifo_err_any <= 1'b1;
            else if (rd_pop)            fifo_err_any <= 1'b0;
            if (push && full)           overrun <= 1'b1;
            else if (rd_pop)            overrun <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || fifo_clr || push || rd_pop || !data_ready) begin
            tcnt    <= '0;
            tmo_irq <= 1'b0;
        end else if (baud_tick && !tmo_irq) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == tmo_limit - 1'b1) tmo_irq <= 1'b1;
        end
    end

    p_tmo_needs_data_r8: assert property (@(posedge clk) disable iff (rst)
        tmo_irq |-> data_ready);

    p_err_flag_set_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && ch_err) |=> fifo_err_any);

    p_overrun_set_r10: assert property (@(posedge clk) disable iff (rst)
        (push && full && !fifo_clr) |=> overrun);

    p_clear_quiets_r6: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> (!data_ready && !tmo_irq && !fifo_err_any && !overrun));

endmodule

// File: tb/serial_rx_queue_test.sv
module serial_rx_queue_test;
    localparam int CLK_PERIOD = 10;
    localparam int BIT        = 16;

    logic clk = 1'b0, rst = 1'b1, tick = 1'b1, rx = 1'b1;
    logic [1:0] wl = 2'd3, tsel = 2'd0;
    logic pen = 1'b0, pev = 1'b0, pst = 1'b0, clr = 1'b0, pop = 1'b0;
    logic [7:0] rd_data;
    logic rd_par_err, rd_frm_err, rd_brk, data_ready, fifo_err_any, overrun;
    logic level_irq, tmo_irq, irq;

    serial_rx_queue uut (
        .clk, .rst, .baud_tick(tick), .rx_in(rx), .word_len(wl),
        .par_en(pen), .par_even(pev), .par_stick(pst), .trig_sel(tsel),
        .fifo_clr(clr), .rd_pop(pop), .rd_data, .rd_par_err, .rd_frm_err,
        .rd_brk, .data_ready, .fifo_err_any, .overrun, .level_irq,
        .tmo_irq, .irq
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0, n_errs = 0;
    bit done = 1'b0;

    // fields: wl[15:14] pen[13] even[12] stick[11] badpar[10] badstop[9] brk[8] data[7:0]
    localparam logic [15:0] VECS [11] = '{
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h35},
        {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h2C},
        {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5B},
        {2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h81},
        {2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C},
        {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC3},
        {2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h10},
        {2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h7E},
        {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00},
        {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] len_mask(input logic [1:0] code);
        return 8'hFF >> (3 - code);
    endfunction

    function automatic logic calc_par(input logic [7:0] d, input logic ev, input logic st);
        if (st) return !ev;
        return ev ? (^d) : !(^d);
    endfunction

    task automatic slot(input logic v);
        @(negedge clk) rx = v;
        repeat (BIT - 1) @(negedge clk);
    endtask

    task automatic send_raw(input logic [7:0] d, input logic pbit, input logic stopv);
        slot(1'b0);
        for (int i = 0; i < 5 + int'(wl); i++) slot(d[i]);
        if (pen) slot(pbit);
        slot(stopv);
        slot(1'b1);
        slot(1'b1);
    endtask

    task automatic send_ok(input logic [7:0] d);
        send_raw(d, calc_par(d & len_mask(wl), pev, pst), 1'b1);
    endtask

    task automatic do_pop();
        @(negedge clk) pop = 1'b1;
        @(negedge clk) pop = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] d, sd, ed;
        logic bp, bs, bk, pex, psent, stopv, epe, efe, ebi;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 data_ready", data_ready, 0);
        check("R11 irq", irq, 0);
        check("R11 tmo_irq", tmo_irq, 0);
        check("R11 fifo_err_any", fifo_err_any, 0);
        check("R11 overrun", overrun, 0);

        // R1 R2 R3 R4 R5 R7: vector table
        for (int i = 0; i < 11; i++) begin
            {wl, pen, pev, pst, bp, bs, bk, d} = VECS[i];
            sd    = bk ? 8'h00 : (d & len_mask(wl));
            pex   = calc_par(sd, pev, pst);
            psent = bk ? 1'b0 : (pex ^ bp);
            stopv = !(bs || bk);
            send_raw(sd, psent, stopv);
            ed  = sd;
            epe = pen && (psent != pex);
            efe = !stopv;
            ebi = (ed == 8'h00) && (!pen || !psent) && !stopv;
            check("R3 data_ready after frame", data_ready, 1);
            check("R1 data", rd_data, ed);
            check("R2 parity flag", rd_par_err, epe);
            check("R4 framing flag", rd_frm_err, efe);
            check("R4 break flag", rd_brk, ebi);
            check("R5 error summary", fifo_err_any, epe || efe || ebi);
            check("R7 level 1", level_irq, 1);
            do_pop();
            check("R3 empty after read", data_ready, 0);
            check("R5 summary cleared by read", fifo_err_any, 0);
        end

        // R9 false start
        wl = 2'd3; pen = 1'b0;
        @(negedge clk) rx = 1'b0;
        repeat (5) @(negedge clk);
        rx = 1'b1;
        repeat (3 * BIT) @(negedge clk);
        check("R9 short pulse ignored", data_ready, 0);
        send_ok(8'h6D);
        check("R9 next frame intact", rd_data, 8'h6D);
        do_pop();

        // R7 R10 fill past capacity
        tsel = 2'd2;
        for (int i = 0; i < 17; i++) begin
            send_ok(8'h40 + 8'(i));
            if (i == 6)  check("R7 level 8 below", level_irq, 0);
            if (i == 7)  begin check("R7 level 8 reached", level_irq, 1); tsel = 2'd3; end
            if (i == 12) check("R7 level 14 below", level_irq, 0);
            if (i == 13) check("R7 level 14 reached", level_irq, 1);
            if (i == 15) check("R10 no overrun at full", overrun, 0);
        end
        check("R10 overrun set", overrun, 1);
        for (int k = 0; k < 16; k++) begin
            check("R10 order kept", rd_data, 8'h40 + 8'(k));
            do_pop();
            if (k == 0) check("R10 overrun cleared by read", overrun, 0);
        end
        check("R10 extra char dropped", data_ready, 0);

        // R6 clear while a frame is in flight
        tsel = 2'd0;
        send_ok(8'h11);
        send_ok(8'h22);
        fork
            send_ok(8'h99);
            begin
                repeat (5 * BIT) @(negedge clk);
                clr = 1'b1;
                @(negedge clk) clr = 1'b0;
                check("R6 queue emptied", data_ready, 0);
            end
        join
        check("R6 in-flight char kept", data_ready, 1);
        check("R6 in-flight data", rd_data, 8'h99);
        do_pop();
        check("R6 only one char", data_ready, 0);

        // R8 timeout with 7-bit characters
        wl = 2'd2; tsel = 2'd3;
        n = 0;
        fork
            send_ok(8'h5A);
            begin
                while (!data_ready) @(negedge clk);
                while (!tmo_irq && n < 2000) begin
                    @(negedge clk);
                    n++;
                end
            end
        join
        check("R8 timeout interval", (n >= 303 && n <= 305) ? 1 : 0, 1);
        check("R8 level quiet", level_irq, 0);
        check("R8 combined irq", irq, 1);
        do_pop();
        check("R8 cleared by read", tmo_irq, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule